// File: doc/BRIEF.md
# Carry-Aware Integer Data-Manipulation Unit

This unit performs a single integer operation per cycle on two operands and a one-bit T flag. The T flag serves as carry in and carry out. It feeds the arithmetic operations with carry or borrow, and the rotates shift bits through it. The remaining operations rearrange bytes, merge half-words, or test byte lanes for equality. These operations pass the T flag through unchanged.

The operation logic is combinational. By default an output register follows it, so `result` and `t_out` are loaded on a rising edge where `in_valid` is high. `out_valid` is asserted for the cycle after such an edge. Setting `REG_OUT` to 0 removes the register, and the outputs then follow the inputs in the same cycle.

Top module: `carry_dmu`

## Requirements
- R1: op 0 (add with carry) gives result = low 32 bits of a + b + T, and new T = bit 32 of that 33-bit sum.
- R2: op 1 (subtract with borrow) gives result = a − b − T modulo 2^32, and new T = 1 exactly when the difference borrows (a < b + T).
- R3: op 2 (negate with borrow) gives result = 0 − a − T modulo 2^32, and new T = 1 unless a and T are both zero.
- R4: op 3 (rotate left through T) gives result {a[30:0], T}, and new T = a[31].
- R5: op 4 (rotate right through T) gives result {T, a[31:1]}, and new T = a[0].
- R6: op 5 (rotate right) rotates a right by b[4:0] places. An amount of 0 returns a unchanged. T passes through.
- R7: op 6 keeps a[31:16] and exchanges byte 0 and byte 1. op 7 reverses all four bytes, giving {a[7:0], a[15:8], a[23:16], a[31:24]}. T passes through for both.
- R8: op 8 (extract) gives {b[15:0], a[31:16]}. T passes through.
- R9: op 9 (byte-lane compare) gives result 1 when at least one of the four bytes of a XOR b is zero, and 0 otherwise. T passes through.
- R10: op codes 10 to 15 are unused. They give result 0 and pass T through unchanged.
- R11: After a cycle with reset high, result = 0, t_out = 0 and out_valid = 0.
- R12: With the register present, an input accepted on a rising edge with in_valid high appears on result and t_out after that edge. out_valid is high for exactly the following cycle.
- R13: On an edge with in_valid low, result and t_out keep their previous values and out_valid goes low, whatever the other inputs are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands and op are valid this cycle |
| op | input | 4 | Operation select (codes in R1 to R10) |
| opa | input | 32 | First operand |
| opb | input | 32 | Second operand, or rotate amount in its low 5 bits |
| t_in | input | 1 | Incoming T flag |
| out_valid | output | 1 | Result registered from the previous cycle's valid input |
| result | output | 32 | Operation result |
| t_out | output | 1 | Updated T flag |

## Verification
Every result and every updated T flag is due exactly one rising edge after the edge that accepts the operands. The bench drives each operation just after a falling edge and lets one rising edge pass. It compares `result`, `t_out` and `out_valid` at the next falling edge, before it drives anything new. The hold checks are timed the same way: a cycle with `in_valid` low and changed inputs is followed one falling edge later by a comparison against the values from the cycle before. Random operations mix with directed carry, borrow, zero-amount rotate and byte-lane cases.

// File: rtl/carry_dmu_pkg.sv
package carry_dmu_pkg;
  localparam int OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_ADDC = 4'd0,
    OP_SUBB = 4'd1,
    OP_NEGB = 4'd2,
    OP_RCLT = 4'd3,
    OP_RCRT = 4'd4,
    OP_ROTR = 4'd5,
    OP_SWLO = 4'd6,
    OP_SWAL = 4'd7,
    OP_XTRC = 4'd8,
    OP_BYEQ = 4'd9
  } dmu_op_e;
endpackage

// File: rtl/cdmu_arith.sv
module cdmu_arith
  import carry_dmu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  dmu_op_e            mode,
  input  logic [WIDTH-1:0]   a,
  input  logic [WIDTH-1:0]   b,
  input  logic               t_in,
  output logic [WIDTH-1:0]   res,
  output logic               t_out
);
  localparam int EW = WIDTH + 1;

  logic [EW-1:0] ext_a, ext_b, ext_t, wide;

  assign ext_a = {1'b0, a};
  assign ext_b = {1'b0, b};
  assign ext_t = {{WIDTH{1'b0}}, t_in};

  always_comb begin
    case (mode)
      OP_ADDC: wide = ext_a + ext_b + ext_t;
      OP_SUBB: wide = ext_a - ext_b - ext_t;
      OP_NEGB: wide = {EW{1'b0}} - ext_a - ext_t;
      default: wide = {EW{1'b0}};
    endcase
  end

  assign res   = wide[WIDTH-1:0];
  assign t_out = wide[WIDTH];
endmodule

// File: rtl/cdmu_rotate.sv
module cdmu_rotate
  import carry_dmu_pkg::*;
#(
  parameter int WIDTH = 32,
  localparam int SHW = $clog2(WIDTH)
) (
  input  dmu_op_e            mode,
  input  logic [WIDTH-1:0]   a,
  input  logic [SHW-1:0]     amt,
  input  logic               t_in,
  output logic [WIDTH-1:0]   res,
  output logic               t_out
);
  logic [2*WIDTH-1:0] doubled;

  // Rotating a doubled copy avoids any shift by the full width at amount 0.
  assign doubled = {a, a} >> amt;

  always_comb begin
    case (mode)
      OP_RCLT: begin
        res   = {a[WIDTH-2:0], t_in};
        t_out = a[WIDTH-1];
      end
      OP_RCRT: begin
        res   = {t_in, a[WIDTH-1:1]};
        t_out = a[0];
      end
      OP_ROTR: begin
        res   = doubled[WIDTH-1:0];
        t_out = t_in;
      end
      default: begin
        res   = '0;
        t_out = t_in;
      end
    endcase
  end
endmodule

// File: rtl/cdmu_bytes.sv
module cdmu_bytes
  import carry_dmu_pkg::*;
#(
  parameter int WIDTH = 32,
  localparam int NBYTES = WIDTH / 8,
  localparam int HALF = WIDTH / 2
) (
  input  dmu_op_e            mode,
  input  logic [WIDTH-1:0]   a,
  input  logic [WIDTH-1:0]   b,
  output logic [WIDTH-1:0]   res
);
  logic [WIDTH-1:0]  reversed;
  logic [WIDTH-1:0]  diff;
  logic [NBYTES-1:0] lane_zero;

  assign diff = a ^ b;

  for (genvar i = 0; i < NBYTES; i++) begin : g_lane
    assign reversed[8*i +: 8] = a[8*(NBYTES-1-i) +: 8];
    assign lane_zero[i]       = (diff[8*i +: 8] == 8'h00);
  end

  always_comb begin
    case (mode)
      OP_SWLO: res = {a[WIDTH-1:16], a[7:0], a[15:8]};
      OP_SWAL: res = reversed;
      OP_XTRC: res = {b[HALF-1:0], a[WIDTH-1:HALF]};
      OP_BYEQ: res = {{(WIDTH-1){1'b0}}, |lane_zero};
      default: res = '0;
    endcase
  end
endmodule

// File: rtl/carry_dmu.sv
module carry_dmu
  import carry_dmu_pkg::*;
#(
  parameter int WIDTH   = 32,
  parameter bit REG_OUT = 1'b1,
  localparam int SHW = $clog2(WIDTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [OP_W-1:0]  op,
  input  logic [WIDTH-1:0] opa,
  input  logic [WIDTH-1:0] opb,
  input  logic             t_in,
  output logic             out_valid,
  output logic [WIDTH-1:0] result,
  output logic             t_out
);
  dmu_op_e op_e;
  assign op_e = dmu_op_e'(op);

  logic [WIDTH-1:0] ar_res, rt_res, by_res, nxt_res;
  logic             ar_t, rt_t, nxt_t;

  cdmu_arith #(.WIDTH(WIDTH)) u_arith (
    .mode(op_e), .a(opa), .b(opb), .t_in(t_in), .res(ar_res), .t_out(ar_t)
  );

  cdmu_rotate #(.WIDTH(WIDTH)) u_rotate (
    .mode(op_e), .a(opa), .amt(opb[SHW-1:0]), .t_in(t_in), .res(rt_res), .t_out(rt_t)
  );

  cdmu_bytes #(.WIDTH(WIDTH)) u_bytes (
    .mode(op_e), .a(opa), .b(opb), .res(by_res)
  );

  always_comb begin
    nxt_res = '0;
    nxt_t   = t_in;
    case (op_e)
      OP_ADDC, OP_SUBB, OP_NEGB: begin
        nxt_res = ar_res;
        nxt_t   = ar_t;
      end
      OP_RCLT, OP_RCRT, OP_ROTR: begin
        nxt_res = rt_res;
        nxt_t   = rt_t;
      end
      OP_SWLO, OP_SWAL, OP_XTRC, OP_BYEQ: nxt_res = by_res;
      default: ;
    endcase
  end

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        result    <= '0;
        t_out     <= 1'b0;
        out_valid <= 1'b0;
      end else begin
        out_valid <= in_valid;
        if (in_valid) begin
          result <= nxt_res;
          t_out  <= nxt_t;
        end
      end
    end

    // R12
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> out_valid);

    // R13
    hold_chk: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> (!out_valid && $stable(result) && $stable(t_out)));
  end else begin : g_comb
    assign result    = nxt_res;
    assign t_out     = nxt_t;
    assign out_valid = in_valid;
  end

  // R1
  add_carry_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op_e == OP_ADDC && !t_in) |-> (ar_t == (ar_res < opa)));

  // R2
  sub_borrow_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op_e == OP_SUBB && !t_in) |-> (ar_t == (opa < opb)));

  // R3
  neg_borrow_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op_e == OP_NEGB && !t_in) |-> (ar_t == (opa != '0)));

  // R6
  rotr_ones_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op_e == OP_ROTR) |-> ($countones(rt_res) == $countones(opa)));

  // R7
  swap_ones_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op_e == OP_SWAL) |-> ($countones(by_res) == $countones(opa)));
endmodule

// File: tb/tb_carry_dmu.sv
`timescale 1ns/1ps
module tb_carry_dmu;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [3:0]  op;
  logic [31:0] opa, opb;
  logic        t_in;
  logic        out_valid;
  logic [31:0] result;
  logic        t_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  carry_dmu dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op(op), .opa(opa), .opb(opb),
    .t_in(t_in), .out_valid(out_valid), .result(result), .t_out(t_out)
  );

  function automatic logic [32:0] model(input logic [3:0] o, input logic [31:0] a,
                                        input logic [31:0] b, input logic t);
    logic [63:0] w;
    logic [31:0] r;
    logic        nt;
    nt = t;
    r  = 32'h0;
    case (o)
      4'd0: begin w = {32'h0, a} + {32'h0, b} + {63'h0, t}; r = w[31:0]; nt = w[32]; end
      4'd1: begin w = {32'h0, a} - {32'h0, b} - {63'h0, t}; r = w[31:0]; nt = w[32]; end
      4'd2: begin w = 64'h0 - {32'h0, a} - {63'h0, t}; r = w[31:0]; nt = w[32]; end
      4'd3: begin r = {a[30:0], t}; nt = a[31]; end
      4'd4: begin r = {t, a[31:1]}; nt = a[0]; end
      4'd5: begin
        r = a;
        for (int k = 0; k < int'(b[4:0]); k++) r = {r[0], r[31:1]};
      end
      4'd6: r = {a[31:16], a[7:0], a[15:8]};
      4'd7: r = {a[7:0], a[15:8], a[23:16], a[31:24]};
      4'd8: r = {b[15:0], a[31:16]};
      4'd9: begin
        w = {32'h0, a ^ b};
        r = ((w[7:0] == 0) || (w[15:8] == 0) || (w[23:16] == 0) || (w[31:24] == 0)) ? 32'd1 : 32'd0;
      end
      default: r = 32'h0;
    endcase
    return {nt, r};
  endfunction

  function automatic string tag_of(input logic [3:0] o);
    case (o)
      4'd0: return "R1";  4'd1: return "R2";  4'd2: return "R3";
      4'd3: return "R4";  4'd4: return "R5";  4'd5: return "R6";
      4'd6, 4'd7: return "R7";  4'd8: return "R8";  4'd9: return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic check(input string req, input logic [33:0] act, input logic [33:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic run_op(input logic [3:0] o, input logic [31:0] a, input logic [31:0] b, input logic t);
    logic [32:0] e;
    e = model(o, a, b, t);
    in_valid = 1'b1; op = o; opa = a; opb = b; t_in = t;
    @(negedge clk);
    check(tag_of(o), {out_valid, t_out, result}, {1'b1, e});
  endtask

  task automatic idle_hold();
    logic [32:0] prev;
    prev = {t_out, result};
    in_valid = 1'b0; op = 4'(($urandom % 10)); opa = $urandom; opb = $urandom; t_in = ~t_in;
    @(negedge clk);
    // R13: outputs unchanged, valid low
    check("R13", {out_valid, t_out, result}, {1'b0, prev});
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rst = 1'b1; in_valid = 1'b1; op = 4'd0; opa = 32'hFFFF_FFFF; opb = 32'h1; t_in = 1'b1;
    @(negedge clk); @(negedge clk);
    // R11: reset state even with valid input present
    check("R11", {out_valid, t_out, result}, 34'h0);
    rst = 1'b0;

    // R1 carry out
    run_op(4'd0, 32'hFFFF_FFFF, 32'h0, 1'b1);
    run_op(4'd0, 32'h1234_5678, 32'h1111_1111, 1'b0);
    // R2 borrow cases
    run_op(4'd1, 32'h0, 32'h0, 1'b1);
    run_op(4'd1, 32'h5, 32'h3, 1'b0);
    run_op(4'd1, 32'h3, 32'h3, 1'b1);
    // R3 zero operand with and without T
    run_op(4'd2, 32'h0, 32'h0, 1'b0);
    run_op(4'd2, 32'h0, 32'h0, 1'b1);
    run_op(4'd2, 32'h8000_0000, 32'h0, 1'b0);
    // R4 / R5
    run_op(4'd3, 32'h8000_0001, 32'h0, 1'b1);
    run_op(4'd4, 32'h0000_0001, 32'h0, 1'b1);
    // R6 amounts 0, 1, 31, upper bits of b ignored
    run_op(4'd5, 32'hDEAD_BEEF, 32'h0, 1'b1);
    run_op(4'd5, 32'hDEAD_BEEF, 32'h1, 1'b0);
    run_op(4'd5, 32'hDEAD_BEEF, 32'hFFFF_FFFF, 1'b1);
    // R7, R8
    run_op(4'd6, 32'h1122_3344, 32'h0, 1'b1);
    run_op(4'd7, 32'h1122_3344, 32'h0, 1'b0);
    run_op(4'd8, 32'hAAAA_5555, 32'h1234_CDEF, 1'b1);
    // R9: one lane equal, none equal, top lane only
    run_op(4'd9, 32'h1122_3344, 32'h5566_3377, 1'b1);
    run_op(4'd9, 32'h1122_3344, 32'h2233_4455, 1'b0);
    run_op(4'd9, 32'hAB00_0000, 32'hABFF_FFFF, 1'b0);
    // R10 unused codes
    run_op(4'd10, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1);
    run_op(4'd15, 32'h1234_5678, 32'h1, 1'b0);
    // R12 / R13
    idle_hold();
    idle_hold();

    for (int i = 0; i < 400; i++) begin
      logic [3:0] o;
      o = ($urandom % 8 == 0) ? 4'(10 + $urandom % 6) : 4'($urandom % 10);
      run_op(o, $urandom, $urandom, 1'($urandom));
      if (i % 37 == 0) idle_hold();
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule